// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

The block is a small timer peripheral on a flat 32-bit register bus with address, write strobe, write data and a combinational read-data path. Its core is a 32-bit reload counter that counts clock cycles. Each time the programmed interval runs out, the counter pulses an interrupt request. The request has no fixed line behind it. It carries a trap vector and a priority that software places in the control register, and an external interrupt controller routes the request by that vector.

The vector can be formed in one of two ways, and a parameter picks one at build time. In legacy form the 8-bit trap field and the 4-bit priority leave the block unchanged and on separate outputs. In remapped form the two top bits of the trap field are ignored, so the vector always falls in 64..127, and the priority is shifted up by two and ORed into the vector. A separate 12-bit down-counter can be loaded and read back. It decrements once per clock and stops at zero.

The interval unit is the bus clock period. A read-only register reports that period in nanoseconds, so software can convert a time into a throttle value.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control, throttle and countdown registers read zero and irq_o is low.
- R2: The control register at offset 0x00 holds the enable in bit 26, the priority in bits 23:20 and the trap number in bits 19:12. A read returns these fields as written, and every other bit reads zero.
- R3: Offset 0x18 reads back the parameter BUS_PERIOD_NS (default 5), and writes to it have no effect.
- R4: With throttle N ≥ 2 at offset 0x10, take the write edge that sets the enable as edge 0. irq_o is first high for one cycle after edge N+1, and then for one cycle every N cycles.
- R5: A throttle value of zero never produces a request.
- R6: A throttle write made while the timer runs does not change the interval in progress. The new value applies from the next reload.
- R7: Clearing the enable stops the counter. irq_o is low from the cycle after that write edge, even where a request was due on that edge.
- R8: In legacy mode (REMAP=0), vec_o equals the trap field and prio_o equals the priority field while irq_o is high.
- R9: In remapped mode (REMAP=1), vec_o is {2'b01, trap[5:0]} ORed with {2'b00, prio, 2'b00}, and prio_o is zero.
- R10: The countdown at offset 0x14 loads wdata[11:0] on a write and reads back in bits 11:0 with the upper bits zero. It drops by one per clock while nonzero and holds at zero.
- R11: The throttle register reads back all 32 written bits, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request pulse |
| vec_o | output | 8 | Trap vector, valid while irq_o is high |
| prio_o | output | 4 | Priority output (zero in remapped mode) |

## Verification
Register reads are combinational. The bench samples them at the falling edge that follows the write edge, and expects countdown values to fall by exactly one per rising edge after that. The bench keeps a count of rising edges and records the edge of each control write. It then expects the first request exactly N+1 edges later and each following one N edges apart, and it compares the edge counts directly rather than polling within a tolerance. A disable write is placed on the edge where a request would fall due. irq_o is then sampled half a cycle after that edge, where it must already be low.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned CD_W     = 12;
  localparam int unsigned TRAP_W   = 8;
  localparam int unsigned PRIO_W   = 4;

  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_THR  = 'h10;
  localparam int unsigned OFF_CD   = 'h14;
  localparam int unsigned OFF_BUSP = 'h18;

  localparam int unsigned EN_BIT   = 26;
  localparam int unsigned PRIO_LSB = 20;
  localparam int unsigned TRAP_LSB = 12;

  typedef struct packed {
    logic              en;
    logic [PRIO_W-1:0] prio;
    logic [TRAP_W-1:0] trap;
  } ctrl_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned BUS_PERIOD_NS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CD_W-1:0]   cd_val_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] thr_o,
  output logic              cd_wr_o,
  output logic [CD_W-1:0]   cd_wdata_o
);
  logic sel_ctrl, sel_thr, sel_cd, sel_busp;
  ctrl_t ctrl_q;
  logic [DATA_W-1:0] thr_q;

  assign sel_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_thr  = addr_i == ADDR_W'(OFF_THR);
  assign sel_cd   = addr_i == ADDR_W'(OFF_CD);
  assign sel_busp = addr_i == ADDR_W'(OFF_BUSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      thr_q  <= '0;
    end else if (we_i) begin
      if (sel_ctrl) begin
        ctrl_q.en   <= wdata_i[EN_BIT];
        ctrl_q.prio <= wdata_i[PRIO_LSB +: PRIO_W];
        ctrl_q.trap <= wdata_i[TRAP_LSB +: TRAP_W];
      end
      if (sel_thr) thr_q <= wdata_i;
    end
  end

  assign cd_wr_o    = we_i && sel_cd;
  assign cd_wdata_o = wdata_i[CD_W-1:0];
  assign ctrl_o     = ctrl_q;
  assign thr_o      = thr_q;

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[EN_BIT]                = ctrl_q.en;
      rdata_o[PRIO_LSB +: PRIO_W]    = ctrl_q.prio;
      rdata_o[TRAP_LSB +: TRAP_W]    = ctrl_q.trap;
    end else if (sel_thr) begin
      rdata_o = thr_q;
    end else if (sel_cd) begin
      rdata_o[CD_W-1:0] = cd_val_i;
    end else if (sel_busp) begin
      rdata_o = DATA_W'(BUS_PERIOD_NS);
    end
  end
endmodule

// File: rtl/pit_cdown.sv
module pit_cdown #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (wr_i)            cnt_q <= wdata_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign val_o = cnt_q;
endmodule

// File: rtl/pit_period.sv
module pit_period #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] thr_i,
  output logic         fire_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         fire_q;

  // cnt_q == 0 means idle/unloaded; reload samples thr_i so late writes apply next period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (!en_i) begin
        cnt_q <= '0;
      end else if (cnt_q == '0) begin
        cnt_q <= thr_i;
      end else if (cnt_q == W'(1)) begin
        cnt_q  <= thr_i;
        fire_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign fire_o = fire_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pit_vector.sv
module pit_vector
  import pit_pkg::*;
#(
  parameter bit REMAP = 1'b0
) (
  input  ctrl_t             ctrl_i,
  output logic [TRAP_W-1:0] vec_o,
  output logic [PRIO_W-1:0] prio_o
);
  generate
    if (REMAP) begin : g_remap
      logic [TRAP_W-1:0] base, prio_sh;
      assign base    = {2'b01, ctrl_i.trap[TRAP_W-3:0]};
      assign prio_sh = {2'b00, ctrl_i.prio, 2'b00};
      assign vec_o   = base | prio_sh;
      assign prio_o  = '0;
    end else begin : g_legacy
      assign vec_o  = ctrl_i.trap;
      assign prio_o = ctrl_i.prio;
    end
  endgenerate
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned BUS_PERIOD_NS = 5,
  parameter bit          REMAP         = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic [7:0]        vec_o,
  output logic [3:0]        prio_o
);
  ctrl_t             ctrl;
  logic              ctrl_en;
  logic [DATA_W-1:0] thr;
  logic [DATA_W-1:0] cnt_q;
  logic [CD_W-1:0]   cd_q;
  logic [CD_W-1:0]   cd_wdata;
  logic              cd_wr;
  logic              fire;

  pit_regs #(.ADDR_W(ADDR_W), .BUS_PERIOD_NS(BUS_PERIOD_NS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .cd_val_i  (cd_q),
    .rdata_o   (rdata_o),
    .ctrl_o    (ctrl),
    .thr_o     (thr),
    .cd_wr_o   (cd_wr),
    .cd_wdata_o(cd_wdata)
  );

  pit_cdown #(.W(CD_W)) u_cdown (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cd_wr),
    .wdata_i(cd_wdata),
    .val_o  (cd_q)
  );

  assign ctrl_en = ctrl.en;

  pit_period #(.W(DATA_W)) u_period (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl_en),
    .thr_i (thr),
    .fire_o(fire),
    .cnt_o (cnt_q)
  );

  pit_vector #(.REMAP(REMAP)) u_vec (
    .ctrl_i(ctrl),
    .vec_o (vec_o),
    .prio_o(prio_o)
  );

  // gate with live enable so a disable on the firing edge suppresses the pulse
  assign irq_o = fire & ctrl_en;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned BUS_PERIOD_NS = 5,
  parameter bit          REMAP         = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic [7:0]        vec_o,
  input logic [3:0]        prio_o,
  input logic              en_i,
  input logic [31:0]       cnt_i,
  input logic [CD_W-1:0]   cd_i,
  input logic              cd_wr_i
);
  a_r10_cd_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_i == '0 && !cd_wr_i) |=> (cd_i == '0));

  a_r10_cd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cd_i != '0 && !cd_wr_i) |=> (cd_i == $past(cd_i) - CD_W'(1)));

  a_r7_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en_i);

  a_r7_stop_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0));

  a_r5_idle_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> !irq_o);

  a_r3_busp_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_BUSP)) |-> (rdata_o == 32'(BUS_PERIOD_NS)));

  generate
    if (REMAP) begin : g_remap_chk
      a_r9_remap_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (vec_o[7:6] == 2'b01 && prio_o == 4'd0));
    end
  endgenerate
endmodule

bind pit_timer pit_timer_chk #(
  .ADDR_W(ADDR_W), .BUS_PERIOD_NS(BUS_PERIOD_NS), .REMAP(REMAP)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .vec_o  (vec_o),
  .prio_o (prio_o),
  .en_i   (ctrl_en),
  .cnt_i  (cnt_q),
  .cd_i   (cd_q),
  .cd_wr_i(cd_wr)
);

// File: tb/pit_timer_bench.sv
`timescale 1ns/1ps
module pit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_r;
  logic        irq, irq_r;
  logic [7:0]  vec, vec_r;
  logic [3:0]  prio, prio_r;
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pit_timer #(.ADDR_W(8), .BUS_PERIOD_NS(5), .REMAP(1'b0)) u_pit_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .vec_o(vec), .prio_o(prio));

  pit_timer #(.ADDR_W(8), .BUS_PERIOD_NS(5), .REMAP(1'b1)) u_pit_timer_remap (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata_r), .irq_o(irq_r), .vec_o(vec_r), .prio_o(prio_r));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // drive at negedge, one write edge, return at following negedge with that edge's index
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output int edge_n);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    edge_n = cyc;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wait_irq(input int maxc, output int at);
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    bus_rd(8'h10, d); chk("R1 thr", d, 32'h0);
    bus_rd(8'h14, d); chk("R1 cd", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    int e;
    bus_wr(8'h00, 32'hFFFF_FFFF, e);
    bus_rd(8'h00, d); chk("R2 ctrl fields", d, 32'h04FF_F000);
    bus_wr(8'h00, 32'h0, e);
    bus_wr(8'h10, 32'hDEAD_BEEF, e);
    bus_rd(8'h10, d); chk("R11 thr 32b", d, 32'hDEAD_BEEF);
    bus_wr(8'h10, 32'h0, e);
    bus_rd(8'h04, d); chk("R11 unmapped 04", d, 32'h0);
    bus_rd(8'h1C, d); chk("R11 unmapped 1C", d, 32'h0);
  endtask

  task automatic t_busp();
    logic [31:0] d;
    int e;
    bus_rd(8'h18, d); chk("R3 busp", d, 32'd5);
    bus_wr(8'h18, 32'd123, e);
    bus_rd(8'h18, d); chk("R3 busp ro", d, 32'd5);
  endtask

  task automatic t_countdown();
    logic [31:0] d;
    int e;
    bus_wr(8'h14, 32'hFFFF_F0C8, e);
    bus_rd(8'h14, d); chk("R10 cd load", d, 32'h0C8);
    repeat (3) @(negedge clk);
    bus_rd(8'h14, d); chk("R10 cd dec", d, 32'h0C5);
    bus_wr(8'h14, 32'd2, e);
    repeat (5) @(negedge clk);
    bus_rd(8'h14, d); chk("R10 cd stop", d, 32'h0);
  endtask

  task automatic t_period();
    int e, c0, a1, a2;
    bus_wr(8'h10, 32'd5, e);
    bus_wr(8'h00, 32'h04AA_5000, c0);
    wait_irq(40, a1);
    chk("R4 first irq edge", 32'(a1 - c0), 32'd6);
    chk("R8 legacy vec", 32'(vec), 32'hA5);
    chk("R8 legacy prio", 32'(prio), 32'hA);
    chk("R9 remap vec", 32'(vec_r), 32'h6D);
    chk("R9 remap prio", 32'(prio_r), 32'h0);
    @(negedge clk);
    chk("R4 single pulse", 32'(irq), 32'h0);
    wait_irq(40, a2);
    chk("R4 period", 32'(a2 - a1), 32'd5);
    bus_wr(8'h00, 32'h0, e);
  endtask

  task automatic t_zero();
    int e, c0, a;
    bus_wr(8'h10, 32'd0, e);
    bus_wr(8'h00, 32'h0400_0000, c0);
    wait_irq(40, a);
    chk("R5 zero thr no irq", 32'(a), 32'hFFFF_FFFF);
    bus_wr(8'h00, 32'h0, e);
  endtask

  task automatic t_reload();
    int e, c0, a1, a2;
    bus_wr(8'h10, 32'd10, e);
    bus_wr(8'h00, 32'h0401_3000, c0);
    repeat (2) @(negedge clk);
    bus_wr(8'h10, 32'd3, e);
    wait_irq(40, a1);
    chk("R6 current interval kept", 32'(a1 - c0), 32'd11);
    chk("R8 legacy vec 13", 32'(vec), 32'h13);
    chk("R9 remap vec 53", 32'(vec_r), 32'h53);
    wait_irq(40, a2);
    chk("R6 new interval", 32'(a2 - a1), 32'd3);
    bus_wr(8'h00, 32'h0, e);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    int e, a;
    bus_wr(8'h10, 32'd2, e);
    bus_wr(8'h00, 32'h0400_0000, e);
    wait_irq(40, a);
    chk("R7 running", 32'(a >= 0), 32'd1);
    @(negedge clk);
    bus_wr(8'h00, 32'h0, e); // write edge is the firing edge
    chk("R7 suppressed at once", 32'(irq), 32'h0);
    wait_irq(20, a);
    chk("R7 stays quiet", 32'(a), 32'hFFFF_FFFF);
    bus_rd(8'h10, d); chk("R7 thr kept", d, 32'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_busp();
    t_countdown();
    t_period();
    t_zero();
    t_reload();
    t_disable();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule